// File: doc/BRIEF.md
# Accumulator Clamp-and-Flag Unit

This unit carries out one instruction: it moves the 32-bit signed multiply-accumulate result into a data register, clamped to the unsigned byte range 0 to 255. It also produces the condition flags for that instruction. The overflow flag is copied from an external sticky overflow-detect bit, and the carry flag is cleared. The negative and zero flags are left as they were.

The architectural status word takes the new flags one instruction late. They are committed when the next instruction issues. Until then, a separate bypassed flag output already shows them, so branch and loop condition logic can use the result at once. The unit only reads the accumulator and the overflow bit and never changes them.

Both forms of the instruction are executed the same way. In the two-register form the source register field is ignored. In the immediate form the immediate operand is ignored. No exception is ever raised.

Top module: `acsat_unit`

## Requirements
- R1: When an issued clamp operation sees a signed accumulator value of 255 or more, the register-file write data one cycle later is 255.
- R2: When an issued clamp operation sees a signed accumulator value of 0 or less (including the most negative value), the write data one cycle later is 0.
- R3: When the signed accumulator value lies between 1 and 254, the write data equals that value.
- R4: The 8-bit result is zero-extended: write data bits 31 to 8 are always 0 when the write enable is high.
- R5: The write enable is high for exactly the one cycle after each issued clamp operation. The write address is then the destination index. The source index has no effect on the address or the data.
- R6: In the cycle after an issue, the bypassed flags `br_flags` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) show V equal to the overflow-detect input sampled at issue, and C equal to 0.
- R7: The status word `stat_flags` (same bit order) does not change on the issue edge of a clamp operation. It takes the pending C and V on the next edge where any instruction issues (`insn_step` high), and it does not change on edges with no instruction.
- R8: Bits N and Z of the status word and of the bypassed flags never change because of a clamp operation.
- R9: `br_flags` equals the pending flags while a commit is outstanding, and equals `stat_flags` otherwise.
- R10: The immediate form (`sat_imm` high) writes the same data to the same register and produces the same flags as the register form.
- R11: After reset, `stat_flags` is 0, `br_flags` is 0 and the write enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_step | input | 1 | An instruction of any kind issues this cycle |
| sat_op | input | 1 | The issuing instruction is the clamp operation |
| sat_imm | input | 1 | Immediate-operand form of the clamp operation |
| src_idx | input | 3 | Source register field (ignored) |
| dst_idx | input | 3 | Destination data register index |
| acc_in | input | 32 | Signed multiply-accumulate result |
| ovf_in | input | 1 | Sticky accumulator overflow-detect bit |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |
| stat_flags | output | 4 | Architectural status word flags {N,Z,C,V} |
| br_flags | output | 4 | Bypassed flags for branch/loop evaluation {N,Z,C,V} |

## Verification
The bench directs accumulator values at the clamp edges: 254, 255, 256, 1, 0, -1, and the two 32-bit extremes. A design that compared unsigned values would send negative values to 255. An off-by-one limit would write 254 or 0 in the wrong place. The bench issues clamp operations back to back and with idle cycles in between. A status word updated on the issue edge, or on an edge with no instruction, would then disagree with the model, and so would a bypass that showed stale flags. Random source indices, immediate forms and ovf patterns expose any dependence on the ignored operand or any mix-up between V and C.

// File: rtl/acsat_pkg.sv
// Package: shared flag layout and limits for the accumulator clamp unit.
// Assumes flags are packed as {N,Z,C,V}, with V in bit 0.
package acsat_pkg;

    localparam int FLAG_W = 4;
    localparam int FL_V   = 0;
    localparam int FL_C   = 1;
    localparam int FL_Z   = 2;
    localparam int FL_N   = 3;

    // Flags this operation defines (C and V); N and Z are held.
    localparam logic [FLAG_W-1:0] UPD_MASK = 4'b0011;

    typedef logic [FLAG_W-1:0] flags_t;

    // Build the flag vector produced by the clamp operation.
    function automatic flags_t make_flags(input logic ovf);
        flags_t f;
        f        = '0;
        f[FL_V]  = ovf;
        f[FL_C]  = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/acsat_clamp.sv
// Module: combinational clamp of a signed accumulator to [0, 2**RES_W-1],
// zero-extended back to DATA_W bits.
// Assumes DATA_W > RES_W + 1, so the upper limit is a positive signed value.
module acsat_clamp #(
    parameter int DATA_W = 32,
    parameter int RES_W  = 8
) (
    input  logic [DATA_W-1:0] acc_in,
    output logic [DATA_W-1:0] clamp_out
);

    localparam int PAD_W = DATA_W - RES_W;
    localparam logic [DATA_W-1:0] MAX_V = DATA_W'((64'd1 << RES_W) - 64'd1);

    logic signed [DATA_W-1:0] acc_s;
    logic        [RES_W-1:0]  res;
    logic                     at_hi;
    logic                     at_lo;

    assign acc_s = $signed(acc_in);

    // Signed compare against both bounds.
    always_comb begin
        at_hi = acc_s >= $signed(MAX_V);
        at_lo = acc_s <= $signed({DATA_W{1'b0}});
    end

    // Select the saturated or the passed-through byte.
    always_comb begin
        if (at_hi) begin
            res = {RES_W{1'b1}};
        end else if (at_lo) begin
            res = '0;
        end else begin
            res = acc_in[RES_W-1:0];
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign clamp_out = {{PAD_W{1'b0}}, res};
        end else begin : g_nopad
            assign clamp_out = res;
        end
    endgenerate

endmodule

// File: rtl/acsat_wrport.sv
// Module: registered register-file write port for the clamp result.
// Assumes one write per issued clamp operation; the source field never
// reaches this stage.
module acsat_wrport #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [DATA_W-1:0] wdata_in,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);

    // Capture the write request; enable lasts a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we    <= 1'b0;
            rf_waddr <= '0;
            rf_wdata <= '0;
        end else begin
            rf_we <= fire;
            if (fire) begin
                rf_waddr <= dst_idx;
                rf_wdata <= wdata_in;
            end
        end
    end

endmodule

// File: rtl/acsat_flagpipe.sv
// Module: pending-flag stage, status word and branch bypass.
// Assumes new flags commit on the next instruction issue after the one
// that produced them; only bits in UPD_MASK are ever written.
module acsat_flagpipe
    import acsat_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   insn_step,
    input  logic   fire,
    input  flags_t new_flags,
    output flags_t stat_flags,
    output flags_t br_flags,
    output logic   pend_vld
);

    flags_t pend_q;
    flags_t stat_q;
    logic   commit;

    assign commit = insn_step && pend_vld;

    // Hold the flags of the last clamp operation until they commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_q   <= '0;
        end else if (fire) begin
            pend_vld <= 1'b1;
            pend_q   <= new_flags;
        end else if (commit) begin
            pend_vld <= 1'b0;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < FLAG_W; gi++) begin : g_bit
            if (UPD_MASK[gi]) begin : g_upd
                // Commit this flag bit from the pending stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        stat_q[gi] <= 1'b0;
                    end else if (commit) begin
                        stat_q[gi] <= pend_q[gi];
                    end
                end
                assign br_flags[gi] = pend_vld ? pend_q[gi] : stat_q[gi];
            end else begin : g_hold
                // Flag not defined by this operation: keep its value.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        stat_q[gi] <= 1'b0;
                    end
                end
                assign br_flags[gi] = stat_q[gi];
            end
        end
    endgenerate

    assign stat_flags = stat_q;

endmodule

// File: rtl/acsat_unit.sv
// Module: top of the accumulator clamp-and-flag unit.
// Assumes sat_op is meaningful only together with insn_step, and that
// register and immediate forms both take only dst_idx into account.
module acsat_unit
    import acsat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RES_W  = 8,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_step,
    input  logic              sat_op,
    input  logic              sat_imm,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              ovf_in,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [FLAG_W-1:0] stat_flags,
    output logic [FLAG_W-1:0] br_flags
);

    logic              fire;
    logic [DATA_W-1:0] clamp_val;
    flags_t            new_flags;
    logic              pend_vld;
    logic              unused_ops;

    // Both encodings execute; operand fields other than dst are dropped.
    assign fire       = insn_step && sat_op;
    assign unused_ops = sat_imm ^ (^src_idx);
    assign new_flags  = make_flags(ovf_in);

    acsat_clamp #(
        .DATA_W (DATA_W),
        .RES_W  (RES_W)
    ) u_clamp (
        .acc_in    (acc_in),
        .clamp_out (clamp_val)
    );

    acsat_wrport #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .dst_idx  (dst_idx),
        .wdata_in (clamp_val),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata)
    );

    acsat_flagpipe u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_step  (insn_step),
        .fire       (fire),
        .new_flags  (new_flags),
        .stat_flags (stat_flags),
        .br_flags   (br_flags),
        .pend_vld   (pend_vld)
    );

endmodule

// File: rtl/acsat_unit_chk.sv
// Module: assertion checker for acsat_unit, attached with bind.
// Assumes it sees the top ports plus the internal pend_vld signal.
module acsat_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_step,
    input logic              sat_op,
    input logic [IDX_W-1:0]  dst_idx,
    input logic [DATA_W-1:0] acc_in,
    input logic              ovf_in,
    input logic              rf_we,
    input logic [IDX_W-1:0]  rf_waddr,
    input logic [DATA_W-1:0] rf_wdata,
    input logic [3:0]        stat_flags,
    input logic [3:0]        br_flags,
    input logic              pend_vld
);

    // R1
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_step && sat_op && $signed(acc_in) >= 255) |=> rf_wdata == 255);

    // R2
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_step && sat_op && $signed(acc_in) <= 0) |=> rf_wdata == 0);

    // R4
    zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_wdata[DATA_W-1:8] == '0);

    // R5
    dst_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_step && sat_op) |=> (rf_we && rf_waddr == $past(dst_idx)));

    // R5
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(insn_step && sat_op) |=> !rf_we);

    // R6
    vflag_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_step && sat_op) |=> (br_flags[0] == $past(ovf_in) && !br_flags[1]));

    // R7
    late_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_step && pend_vld) |=> stat_flags[1:0] == $past(br_flags[1:0]));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_step |=> $stable(stat_flags));

    // R8
    nz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(stat_flags[3:2]) && br_flags[3:2] == stat_flags[3:2]);

    // R9
    bypass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_vld |-> br_flags == stat_flags);

endmodule

bind acsat_unit acsat_unit_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_step  (insn_step),
    .sat_op     (sat_op),
    .dst_idx    (dst_idx),
    .acc_in     (acc_in),
    .ovf_in     (ovf_in),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .stat_flags (stat_flags),
    .br_flags   (br_flags),
    .pend_vld   (pend_vld)
);

// File: tb/acsat_unit_test.sv
module acsat_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_step = 1'b0;
    logic        sat_op = 1'b0;
    logic        sat_imm = 1'b0;
    logic [2:0]  src_idx = '0;
    logic [2:0]  dst_idx = '0;
    logic [31:0] acc_in = '0;
    logic        ovf_in = 1'b0;
    logic        rf_we;
    logic [2:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic [3:0]  stat_flags;
    logic [3:0]  br_flags;

    int n_chk = 0;
    int n_err = 0;

    // Reference model state
    logic [3:0]  m_stat = '0;
    logic        m_pend = 1'b0;
    logic [1:0]  m_pcv  = '0;
    logic        m_we   = 1'b0;
    logic [2:0]  m_addr = '0;
    logic [31:0] m_data = '0;

    acsat_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_step  (insn_step),
        .sat_op     (sat_op),
        .sat_imm    (sat_imm),
        .src_idx    (src_idx),
        .dst_idx    (dst_idx),
        .acc_in     (acc_in),
        .ovf_in     (ovf_in),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .stat_flags (stat_flags),
        .br_flags   (br_flags)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] exp_clamp(input logic [31:0] a);
        if ($signed(a) >= 255) return 32'd255;
        if ($signed(a) <= 0)   return 32'd0;
        return a;
    endfunction

    function automatic logic [3:0] exp_br();
        if (m_pend) return {m_stat[3:2], m_pcv};
        return m_stat;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string data_req(input logic [31:0] a);
        if ($signed(a) >= 255) return "R1";
        if ($signed(a) <= 0)   return "R2";
        return "R3";
    endfunction

    logic [31:0] last_acc = '0;

    // Drive one cycle, advance the model, compare at the falling edge.
    task automatic cycle(input logic st, input logic op, input logic imm,
                         input logic [2:0] src, input logic [2:0] dst,
                         input logic [31:0] acc, input logic ovf);
        insn_step = st; sat_op = op; sat_imm = imm;
        src_idx = src; dst_idx = dst; acc_in = acc; ovf_in = ovf;
        @(posedge clk);
        m_we = st && op;
        if (m_we) begin
            m_addr = dst;
            m_data = exp_clamp(acc);
            last_acc = acc;
        end
        if (st && m_pend) begin
            m_stat[1:0] = m_pcv;
            m_pend = 1'b0;
        end
        if (st && op) begin
            m_pend = 1'b1;
            m_pcv  = {1'b0, ovf};
        end
        @(negedge clk);
        check("R5 we", {31'd0, rf_we}, {31'd0, m_we});
        if (m_we) begin
            check("R5 addr", {29'd0, rf_waddr}, {29'd0, m_addr});
            check(data_req(last_acc), rf_wdata, m_data);
            check("R4", {8'd0, rf_wdata[31:8]}, 32'd0);
            check("R6", {30'd0, br_flags[1:0]}, {30'd0, m_pcv});
        end
        check("R7", {28'd0, stat_flags}, {28'd0, m_stat});
        check("R8", {30'd0, stat_flags[3:2]}, 32'd0);
        check("R9", {28'd0, br_flags}, {28'd0, exp_br()});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] corners [0:9];
        void'($urandom(32'd1234));
        corners[0] = 32'd254; corners[1] = 32'd255; corners[2] = 32'd256;
        corners[3] = 32'd1;   corners[4] = 32'd0;   corners[5] = 32'hFFFF_FFFF;
        corners[6] = 32'h7FFF_FFFF; corners[7] = 32'h8000_0000;
        corners[8] = 32'd128; corners[9] = 32'hFFFF_FF01;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check("R11 stat", {28'd0, stat_flags}, 32'd0);
        check("R11 br", {28'd0, br_flags}, 32'd0);
        check("R11 we", {31'd0, rf_we}, 32'd0);

        // Directed corners, register form, with idle gaps
        for (int i = 0; i < 10; i++) begin
            cycle(1'b1, 1'b1, 1'b0, 3'(i), 3'(i + 3), corners[i], i[0]);
            cycle(1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 32'd0, 1'b0);
            cycle(1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 32'd0, 1'b0);
        end

        // R10: immediate form matches register form
        cycle(1'b1, 1'b1, 1'b1, 3'd7, 3'd2, 32'd77, 1'b1);
        check("R10 data", rf_wdata, 32'd77);
        check("R10 addr", {29'd0, rf_waddr}, 32'd2);
        check("R10 V", {31'd0, br_flags[0]}, 32'd1);
        cycle(1'b1, 1'b1, 1'b1, 3'd1, 3'd5, 32'hFFFF_FF00, 1'b0);
        check("R10 low", rf_wdata, 32'd0);

        // Back-to-back operations
        for (int i = 0; i < 6; i++)
            cycle(1'b1, 1'b1, 1'b0, 3'(i), 3'(7 - i), corners[i], ~i[0]);

        // Constrained random
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            logic [2:0]  sel;
            sel = 3'($urandom_range(0, 4));
            case (sel)
                3'd0:    a = 32'($urandom_range(0, 300));
                3'd1:    a = -32'($urandom_range(0, 300));
                3'd2:    a = corners[$urandom_range(0, 9)];
                default: a = $urandom;
            endcase
            cycle(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 3'($urandom), 3'($urandom),
                  a, 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule